// File: doc/BRIEF.md
# Expansion ROM Target Decoder

This block sits in a bus target and decides whether an incoming access belongs to the expansion-ROM window. A programmable base register supplies the window position in its upper bits and a window-enable flag in bit 0. The window size is a power of two set by a parameter. Only the address bits above that size are compared.

A claimed memory write is posted. Its byte offset inside the window and its data are offered to the inbound queue, and the master is told to disconnect after that single data phase. A claimed memory read is answered with retry, and a one-cycle strobe carrying the address and command goes to a separate delayed-read tracker. Every other command is left unclaimed. Each request produces one registered response, one cycle after the edge that samples it.

The push to the inbound queue is a valid/ready interface with single-cycle offers. `push_valid` is offered for exactly one cycle per claimed write. The entry moves only if `push_ready` is high in that same cycle. If `push_ready` is low, the offer is withdrawn, the write is answered with retry, and the master repeats it later. The decoder never holds an offer across cycles, so back-pressure from the queue always becomes retry on the bus.

Top module: `rom_target_decode`

## Requirements
- R1: An access is claimed only when `rom_base[0]` is 1 and `req_addr[31:WIN_LG]` equals `rom_base[31:WIN_LG]`. Otherwise the response code is NONE (2'b00), and neither `push_valid` nor `dread_valid` rises.
- R2: A claimed memory write (cmd 4'h7) or write-and-invalidate (cmd 4'h0F) with `push_ready` high transfers one entry. That entry holds `push_addr` = `req_addr[WIN_LG-1:0]` and `push_data` = `req_data`, and the response code is DISCONNECT (2'b01).
- R3: A claimed write that meets `push_ready` low is answered with RETRY (2'b10), and no entry is transferred.
- R4: A claimed memory read (4'h6), read-multiple (4'hC) or read-line (4'hE) is answered with RETRY. It also raises `dread_valid` for one cycle with `dread_addr` = `req_addr` and `dread_cmd` = `req_cmd`, and it never offers a push.
- R5: Any other command, even to a matching address, gives NONE with no push and no delayed-read strobe.
- R6: `resp_valid` is high exactly in the cycle after each edge that samples `req_valid` high, and low otherwise.
- R7: During and right after reset, `resp_valid`, `push_valid` and `dread_valid` are low.
- R8: Byte enables change neither the response nor the pushed address and data. A write with all enables clear still pushes exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_cmd | input | 4 | Bus command code |
| req_be | input | 4 | Byte enables (no effect on decode) |
| req_data | input | 32 | Write data |
| rom_base | input | 32 | Window base in upper bits, enable in bit 0 |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 00 none, 01 disconnect, 10 retry |
| push_valid | output | 1 | Inbound queue entry offered |
| push_ready | input | 1 | Inbound queue can take the entry |
| push_addr | output | WIN_LG | Byte offset inside the window |
| push_data | output | 32 | Write data to post |
| dread_valid | output | 1 | Delayed-read handoff strobe |
| dread_addr | output | 32 | Read address for the tracker |
| dread_cmd | output | 4 | Read command for the tracker |

## Verification
The bench targets the addresses on either side of the window's upper and lower edges. A compare that is one bit too wide or too narrow would claim an outside address or miss an inside one. It toggles the enable bit while the address matches, so a decoder that ignores that bit shows up as claiming accesses it should leave. It holds the queue not-ready under claimed writes, where a faulty design would report disconnect or let an entry through. It also sends writes with every byte-enable pattern and non-memory commands into a live window; a design that filtered by enables or decoded loosely would push, drop or strobe at the wrong time.

// File: rtl/rom_dec_pkg.sv
package rom_dec_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_DISC  = 2'b01,
    RSP_RETRY = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_WRITE = 2'b01,
    CLS_READ  = 2'b10
  } cls_e;

  localparam logic [3:0] CMD_MEM_RD      = 4'h6;
  localparam logic [3:0] CMD_MEM_WR      = 4'h7;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;
  localparam logic [3:0] CMD_MEM_WR_INV  = 4'hF;
endpackage

// File: rtl/rom_win_match.sv
module rom_win_match #(
  parameter int ADDR_W = 32,
  parameter int WIN_LG = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_LG;

  logic [TAG_W-1:0] addr_tag;
  logic [TAG_W-1:0] base_tag;
  logic             win_en;
  logic             unused_low_bits;

  assign addr_tag = addr[ADDR_W-1:WIN_LG];
  assign base_tag = base[ADDR_W-1:WIN_LG];
  assign win_en   = base[0];

  generate
    if (WIN_LG > 1) begin : g_spare
      assign unused_low_bits = ^{base[WIN_LG-1:1], addr[WIN_LG-1:0]};
    end else begin : g_nospare
      assign unused_low_bits = ^addr[WIN_LG-1:0];
    end
  endgenerate

  assign hit = win_en && (addr_tag == base_tag);
endmodule

// File: rtl/rom_cmd_class.sv
module rom_cmd_class
  import rom_dec_pkg::*;
(
  input  logic [3:0] cmd,
  output cls_e       cls
);
  always_comb begin
    unique case (cmd)
      CMD_MEM_WR, CMD_MEM_WR_INV:                   cls = CLS_WRITE;
      CMD_MEM_RD, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE: cls = CLS_READ;
      default:                                      cls = CLS_OTHER;
    endcase
  end
endmodule

// File: rtl/rom_req_stage.sv
module rom_req_stage
  import rom_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_hit,
  input  cls_e              in_cls,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [3:0]        in_cmd,
  input  logic [DATA_W-1:0] in_data,
  output logic              q_valid,
  output logic              q_hit,
  output cls_e              q_cls,
  output logic [ADDR_W-1:0] q_addr,
  output logic [3:0]        q_cmd,
  output logic [DATA_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_hit   <= 1'b0;
      q_cls   <= CLS_OTHER;
    end else begin
      q_valid <= in_valid;
      q_hit   <= in_valid && in_hit;
      q_cls   <= in_cls;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      q_addr <= in_addr;
      q_cmd  <= in_cmd;
      q_data <= in_data;
    end
  end
endmodule

// File: rtl/rom_target_decode.sv
module rom_target_decode
  import rom_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LG = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ADDR_W-1:0] rom_base,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WIN_LG-1:0] push_addr,
  output logic [DATA_W-1:0] push_data,
  output logic              dread_valid,
  output logic [ADDR_W-1:0] dread_addr,
  output logic [3:0]        dread_cmd
);
  logic              in_hit;
  cls_e              in_cls;
  logic              s_valid;
  logic              s_hit;
  cls_e              s_cls;
  logic [ADDR_W-1:0] s_addr;
  logic [3:0]        s_cmd;
  logic [DATA_W-1:0] s_data;
  logic              claim_wr;
  logic              claim_rd;
  rsp_e              rsp;
  logic              unused_be;

  // Byte enables have no say in the decode: one posted write per request.
  assign unused_be = ^req_be;

  rom_win_match #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG)) u_match (
    .addr (req_addr),
    .base (rom_base),
    .hit  (in_hit)
  );

  rom_cmd_class u_class (
    .cmd (req_cmd),
    .cls (in_cls)
  );

  rom_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_hit   (in_hit),
    .in_cls   (in_cls),
    .in_addr  (req_addr),
    .in_cmd   (req_cmd),
    .in_data  (req_data),
    .q_valid  (s_valid),
    .q_hit    (s_hit),
    .q_cls    (s_cls),
    .q_addr   (s_addr),
    .q_cmd    (s_cmd),
    .q_data   (s_data)
  );

  assign claim_wr = s_valid && s_hit && (s_cls == CLS_WRITE);
  assign claim_rd = s_valid && s_hit && (s_cls == CLS_READ);

  always_comb begin
    if (claim_wr)      rsp = push_ready ? RSP_DISC : RSP_RETRY;
    else if (claim_rd) rsp = RSP_RETRY;
    else               rsp = RSP_NONE;
  end

  assign resp_valid  = s_valid;
  assign resp_code   = rsp;
  assign push_valid  = claim_wr;
  assign push_addr   = s_addr[WIN_LG-1:0];
  assign push_data   = s_data;
  assign dread_valid = claim_rd;
  assign dread_addr  = s_addr;
  assign dread_cmd   = s_cmd;
endmodule

// File: rtl/rom_target_decode_chk.sv
module rom_target_decode_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] rom_base,
  input logic              resp_valid,
  input logic [1:0]        resp_code,
  input logic              push_valid,
  input logic              push_ready,
  input logic              dread_valid
);
  // R2: an entry that moves is always reported as disconnect
  a_r2_xfer_disc: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |-> (resp_valid && resp_code == 2'b01));

  // R3: a retried write never moves an entry
  a_r3_retry_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == 2'b10) |-> !(push_valid && push_ready));

  // R4: the read handoff goes with retry and never with a push
  a_r4_read_retry: assert property (@(posedge clk) disable iff (!rst_n)
    dread_valid |-> (resp_valid && resp_code == 2'b10 && !push_valid));

  // R5, R1: an unclaimed access is quiet
  a_r5_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_code == 2'b00) |-> (!push_valid && !dread_valid));

  // R1: a claim needs the enable bit at the sampling edge
  a_r1_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || dread_valid) |-> $past(rom_base[0]));

  // R6: a response follows a sampled request
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid));

  // R7: nothing is offered with no response
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!push_valid && !dread_valid));
endmodule

bind rom_target_decode rom_target_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .rom_base    (rom_base),
  .resp_valid  (resp_valid),
  .resp_code   (resp_code),
  .push_valid  (push_valid),
  .push_ready  (push_ready),
  .dread_valid (dread_valid)
);

// File: tb/rom_target_decode_bench.sv
module rom_target_decode_bench;
  localparam int WIN_LG = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_data = '0;
  logic [31:0] rom_base = '0;
  logic        push_ready = 1'b0;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic        push_valid;
  logic [WIN_LG-1:0] push_addr;
  logic [31:0] push_data;
  logic        dread_valid;
  logic [31:0] dread_addr;
  logic [3:0]  dread_cmd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rom_target_decode #(.WIN_LG(WIN_LG)) u_rom_target_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_be(req_be), .req_data(req_data), .rom_base(rom_base),
    .resp_valid(resp_valid), .resp_code(resp_code), .push_valid(push_valid),
    .push_ready(push_ready), .push_addr(push_addr), .push_data(push_data),
    .dread_valid(dread_valid), .dread_addr(dread_addr), .dread_cmd(dread_cmd)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit f_hit(logic [31:0] a, logic [31:0] b);
    return b[0] && (a[31:WIN_LG] == b[31:WIN_LG]);
  endfunction
  function automatic bit f_wr(logic [3:0] c);
    return c == 4'h7 || c == 4'hF;
  endfunction
  function automatic bit f_rd(logic [3:0] c);
    return c == 4'h6 || c == 4'hC || c == 4'hE;
  endfunction
  function automatic logic [1:0] f_code(logic [31:0] a, logic [3:0] c, logic [31:0] b, bit rdy);
    if (f_hit(a, b) && f_wr(c)) return rdy ? 2'b01 : 2'b10;
    if (f_hit(a, b) && f_rd(c)) return 2'b10;
    return 2'b00;
  endfunction
  function automatic string f_tag(logic [31:0] a, logic [3:0] c, logic [31:0] b, bit rdy);
    if (!f_hit(a, b)) return "R1";
    if (f_wr(c)) return rdy ? "R2" : "R3";
    if (f_rd(c)) return "R4";
    return "R5";
  endfunction

  task automatic txn(logic [31:0] a, logic [3:0] c, logic [3:0] be,
                     logic [31:0] d, logic [31:0] b, bit rdy);
    string tag;
    bit    ew;
    bit    er;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c; req_be = be;
    req_data = d; rom_base = b; push_ready = rdy;
    @(negedge clk);
    req_valid = 1'b0;
    tag = f_tag(a, c, b, rdy);
    ew = f_hit(a, b) && f_wr(c);
    er = f_hit(a, b) && f_rd(c);
    check("R6", "resp_valid", {31'd0, resp_valid}, 32'd1);
    check(tag, "resp_code", {30'd0, resp_code}, {30'd0, f_code(a, c, b, rdy)});
    check(tag, "push_valid", {31'd0, push_valid}, {31'd0, ew});
    check(tag, "dread_valid", {31'd0, dread_valid}, {31'd0, er});
    if (ew) begin
      check(tag, "push_addr", {{(32-WIN_LG){1'b0}}, push_addr}, {{(32-WIN_LG){1'b0}}, a[WIN_LG-1:0]});
      check(tag, "push_data", push_data, d);
    end
    if (er) begin
      check("R4", "dread_addr", dread_addr, a);
      check("R4", "dread_cmd", {28'd0, dread_cmd}, {28'd0, c});
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    logic [31:0] saved;
    void'($urandom(32'd1234));
    base = 32'h000A_0001;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "resp_valid in reset", {31'd0, resp_valid}, 32'd0);
    check("R7", "push_valid in reset", {31'd0, push_valid}, 32'd0);
    check("R7", "dread_valid in reset", {31'd0, dread_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    check("R7", "push_valid after reset", {31'd0, push_valid}, 32'd0);

    // R1: window edges and enable bit
    txn(32'h000A_0000, 4'h7, 4'hF, 32'h1111_0000, base, 1'b1);
    txn(32'h000A_FFFC, 4'h7, 4'hF, 32'h2222_0000, base, 1'b1);
    txn(32'h000B_0000, 4'h7, 4'hF, 32'h3333_0000, base, 1'b1);
    txn(32'h0009_FFFC, 4'h6, 4'hF, 32'h0, base, 1'b1);
    txn(32'h000A_0040, 4'h7, 4'hF, 32'h4444_0000, 32'h000A_0000, 1'b1);
    txn(32'h000A_0040, 4'hE, 4'hF, 32'h0, 32'h000A_0000, 1'b1);
    // R2: write-and-invalidate
    txn(32'h000A_1234, 4'hF, 4'h3, 32'hCAFE_F00D, base, 1'b1);
    // R3: queue full
    txn(32'h000A_0100, 4'h7, 4'hF, 32'hDEAD_BEEF, base, 1'b0);
    txn(32'h000A_0104, 4'hF, 4'hF, 32'hDEAD_0001, base, 1'b0);
    // R4: each read kind
    txn(32'h000A_0200, 4'h6, 4'hF, 32'h0, base, 1'b0);
    txn(32'h000A_0204, 4'hC, 4'hF, 32'h0, base, 1'b1);
    txn(32'h000A_0208, 4'hE, 4'h0, 32'h0, base, 1'b1);
    // R5: other commands into a live window
    txn(32'h000A_0300, 4'h2, 4'hF, 32'h0, base, 1'b1);
    txn(32'h000A_0300, 4'h3, 4'hF, 32'h5, base, 1'b1);
    txn(32'h000A_0300, 4'hB, 4'hF, 32'h5, base, 1'b1);
    // R6: idle cycle after a response
    @(negedge clk);
    check("R6", "resp_valid idle", {31'd0, resp_valid}, 32'd0);
    check("R6", "push_valid idle", {31'd0, push_valid}, 32'd0);
    // R8: byte enables do not matter
    for (int be = 0; be < 16; be++) begin
      txn(32'h000A_0400 + 32'(be * 4), 4'h7, 4'(be), 32'h8800_0000 + 32'(be), base, 1'b1);
    end
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [3:0]  c;
      logic [31:0] b;
      b = {12'h000, 4'($urandom_range(0, 3)), 15'h0, 1'b1};
      if ($urandom_range(0, 5) == 0) b[0] = 1'b0;
      a = $urandom();
      if ($urandom_range(0, 3) != 0) a[31:WIN_LG] = b[31:WIN_LG];
      c = ($urandom_range(0, 2) == 0) ? 4'($urandom()) :
          (($urandom_range(0, 1) == 0) ? 4'h7 : 4'h6);
      saved = $urandom();
      txn(a, c, 4'($urandom()), saved, b, 1'($urandom()));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule